// File: doc/BRIEF.md
# MSB-First Interval-Bounded Multiplier

This block multiplies two unsigned operands iteratively, taking the multiplier operand one bit group per clock. It starts at the most significant group and works toward the least significant one. Because the large contributions arrive first, the running sum is already close to the product after the first phase. After every phase the block presents two bounds, and the exact product is guaranteed to lie between them. It also presents the distance between the two bounds, so a consumer can read an approximate product together with its worst-case error at any phase boundary.

A controller loads the operands, an error limit and a phase budget with a single start pulse. The computation ends at the first of these events:
- the interval width falls to or below the error limit;
- the phase budget is used up;
- all groups have been consumed;
- the controller raises a halt request.

When it ends, the bounds in place at that moment are the result. The done flag then stays high until the next start.

Top module: `mbm_interval_mult`

## Requirements
- R1: While reset is asserted and after its release, done, phase_valid, phase, lo_bound, hi_bound and span are all zero.
- R2: A start seen while the unit is not running captures a_in, b_in, err_limit and phase_limit. At the next edge done is 0, phase is 0, lo_bound is 0 and hi_bound is a·(2^W−1).
- R3: After phase p, with r = W − p·G (G = W/GROUPS), lo_bound equals a·(b with its low r bits cleared) and hi_bound equals lo_bound + a·(2^r−1). The exact product always satisfies lo_bound ≤ a·b ≤ hi_bound.
- R4: span always equals hi_bound − lo_bound and never increases from one phase to the next.
- R5: After phase GROUPS, lo_bound = hi_bound = a·b and span = 0, and done is set.
- R6: If span ≤ err_limit after a phase, done rises on the same edge as that phase's phase_valid, and no further phase runs.
- R7: The budget is phase_limit, or GROUPS when phase_limit is 0 or larger than GROUPS. The unit stops after the phase whose index reaches the budget.
- R8: halt sampled high while running ends the operation at that edge. done rises, phase_valid stays low, and the bounds and phase keep their previous values.
- R9: start and new operand values presented while the unit is running are ignored. The bounds keep following the captured operands.
- R10: Once done is set, it stays high and the bounds, span and phase stay unchanged until the next accepted start, which clears done.
- R11: phase_valid is a one-cycle strobe per completed phase. Phase indices run 1, 2, … from the first phase, and phase_valid is never high with phase equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while running) |
| a_in | input | W | Multiplicand |
| b_in | input | W | Multiplier, consumed most significant group first |
| err_limit | input | 2W | Stop once span is at or below this value |
| phase_limit | input | PW | Phase budget; 0 or above GROUPS means GROUPS |
| halt | input | 1 | Controller request to stop now |
| lo_bound | output | 2W | Lower bound of the product |
| hi_bound | output | 2W | Upper bound of the product |
| span | output | 2W | hi_bound − lo_bound |
| phase | output | PW | Number of completed phases |
| phase_valid | output | 1 | Pulses when a phase completes |
| done | output | 1 | Operation finished or stopped |

## Verification
The bench computes both bounds for every phase from the captured operands and watches for an off-by-one in the remaining-bit count r. Such a slip would put the upper bound below the exact product or leave a non-zero width after the last phase.

It drives all-ones operands to reach the largest product, and a zero multiplicand, whose width collapses at the first phase. It also sets error limits exactly equal to a phase's width, where a strict compare would run one phase too many.

It raises halt both before any phase and mid-run. It uses budgets of zero and above the group count, and issues a start with different operands during a run. A design that mishandled these would overrun the budget, strobe a phase after a halt, or switch operands mid-computation.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mbm_state_e;
endpackage

// File: rtl/mbm_phase_step.sv
// One refinement phase: add the selected multiplier group's contribution
// to the lower bound and form the remaining uncertainty.
module mbm_phase_step #(
  parameter int W      = 64,
  parameter int GROUPS = 4,
  parameter int PW     = $clog2(GROUPS + 1)
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [2*W-1:0] lo,
  input  logic [PW-1:0]  idx,     // completed phases so far (0-based next group)
  output logic [2*W-1:0] lo_nxt,
  output logic [2*W-1:0] hi_nxt,
  output logic [2*W-1:0] span_nxt
);
  localparam int G     = W / GROUPS;
  localparam int PRODW = 2 * W;

  logic [G-1:0]       grp_arr [GROUPS];
  logic [G-1:0]       grp;
  logic [PW-1:0]      sel;
  logic [PRODW-1:0]   a_wide;
  logic [PRODW-1:0]   pp;
  int                 rem;

  // Group 0 is the most significant slice of the multiplier.
  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_slice
    assign grp_arr[gi] = b[W-1-gi*G -: G];
  end

  always_comb begin
    if (idx < PW'(GROUPS)) sel = idx;
    else                   sel = PW'(GROUPS - 1);
    grp      = grp_arr[sel];
    rem      = W - (int'(sel) + 1) * G;
    a_wide   = {{W{1'b0}}, a};
    pp       = a_wide * {{(PRODW-G){1'b0}}, grp};
    lo_nxt   = lo + (pp << rem);
    span_nxt = (a_wide << rem) - a_wide;
    hi_nxt   = lo_nxt + span_nxt;
  end
endmodule

// File: rtl/mbm_stop_judge.sv
// Decides whether the phase being completed ends the operation.
module mbm_stop_judge #(
  parameter int W      = 64,
  parameter int GROUPS = 4,
  parameter int PW     = $clog2(GROUPS + 1)
) (
  input  logic [2*W-1:0] span_nxt,
  input  logic [2*W-1:0] limit,
  input  logic [PW-1:0]  phase_nxt,
  input  logic [PW-1:0]  budget_in,
  output logic           finish
);
  logic [PW-1:0] budget;

  always_comb begin
    if (budget_in == '0 || budget_in > PW'(GROUPS)) budget = PW'(GROUPS);
    else                                            budget = budget_in;
    finish = (span_nxt <= limit) || (phase_nxt >= budget);
  end
endmodule

// File: rtl/mbm_interval_mult.sv
module mbm_interval_mult
  import mbm_pkg::*;
#(
  parameter int W      = 64,
  parameter int GROUPS = 4,
  parameter int PW     = $clog2(GROUPS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  input  logic [2*W-1:0] err_limit,
  input  logic [PW-1:0]  phase_limit,
  input  logic           halt,
  output logic [2*W-1:0] lo_bound,
  output logic [2*W-1:0] hi_bound,
  output logic [2*W-1:0] span,
  output logic [PW-1:0]  phase,
  output logic           phase_valid,
  output logic           done
);
  localparam int PRODW = 2 * W;

  mbm_state_e       st_q, st_d;
  logic [W-1:0]     a_q, a_d, b_q, b_d;
  logic [PRODW-1:0] lim_q, lim_d;
  logic [PW-1:0]    plim_q, plim_d;
  logic [PRODW-1:0] lo_q, lo_d, hi_q, hi_d, span_q, span_d;
  logic [PW-1:0]    ph_q, ph_d;
  logic             pv_q, pv_d, done_q, done_d;

  logic [PRODW-1:0] step_lo, step_hi, step_span, init_span;
  logic [PW-1:0]    ph_inc;
  logic             finish;

  assign ph_inc    = ph_q + 1'b1;
  assign init_span = ({{W{1'b0}}, a_in} << W) - {{W{1'b0}}, a_in};

  mbm_phase_step #(.W(W), .GROUPS(GROUPS), .PW(PW)) u_step (
    .a(a_q), .b(b_q), .lo(lo_q), .idx(ph_q),
    .lo_nxt(step_lo), .hi_nxt(step_hi), .span_nxt(step_span)
  );

  mbm_stop_judge #(.W(W), .GROUPS(GROUPS), .PW(PW)) u_judge (
    .span_nxt(step_span), .limit(lim_q), .phase_nxt(ph_inc),
    .budget_in(plim_q), .finish(finish)
  );

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    a_d    = a_q;
    b_d    = b_q;
    lim_d  = lim_q;
    plim_d = plim_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    span_d = span_q;
    ph_d   = ph_q;
    pv_d   = 1'b0;
    done_d = done_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_RUN;
          a_d    = a_in;
          b_d    = b_in;
          lim_d  = err_limit;
          plim_d = phase_limit;
          lo_d   = '0;
          hi_d   = init_span;
          span_d = init_span;
          ph_d   = '0;
          done_d = 1'b0;
        end
      end
      ST_RUN: begin
        if (halt) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          lo_d   = step_lo;
          hi_d   = step_hi;
          span_d = step_span;
          ph_d   = ph_inc;
          pv_d   = 1'b1;
          if (finish) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      a_q    <= '0;
      b_q    <= '0;
      lim_q  <= '0;
      plim_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      span_q <= '0;
      ph_q   <= '0;
      pv_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      a_q    <= a_d;
      b_q    <= b_d;
      lim_q  <= lim_d;
      plim_q <= plim_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      span_q <= span_d;
      ph_q   <= ph_d;
      pv_q   <= pv_d;
      done_q <= done_d;
    end
  end

  assign lo_bound    = lo_q;
  assign hi_bound    = hi_q;
  assign span        = span_q;
  assign phase       = ph_q;
  assign phase_valid = pv_q;
  assign done        = done_q;

  // Assertions
  assert_bounds_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_q <= hi_q);

  assert_span_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    span_q == hi_q - lo_q);

  assert_span_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !halt) |=> span_q <= $past(span_q));

  assert_final_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && ph_q == PW'(GROUPS)) |-> (span_q == '0 && done_q));

  assert_halt_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && halt) |=> (done_q && !pv_q && $stable(lo_q) && $stable(ph_q)));

  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |=> ($stable(a_q) && $stable(b_q)));

  assert_done_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> (done_q && $stable(lo_q) && $stable(hi_q)));

  assert_strobe_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q |-> ph_q != '0);
endmodule

// File: tb/mbm_interval_mult_test.sv
module mbm_interval_mult_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;
  localparam int GROUPS = 4;
  localparam int G = W / GROUPS;
  localparam int PW = 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [W-1:0]   a_in, b_in;
  logic [2*W-1:0] err_limit;
  logic [PW-1:0]  phase_limit;
  logic           halt;
  logic [2*W-1:0] lo_bound, hi_bound, span;
  logic [PW-1:0]  phase;
  logic           phase_valid, done;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbm_interval_mult #(.W(W), .GROUPS(GROUPS), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .err_limit(err_limit), .phase_limit(phase_limit), .halt(halt),
    .lo_bound(lo_bound), .hi_bound(hi_bound), .span(span), .phase(phase),
    .phase_valid(phase_valid), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_lo(input logic [W-1:0] a, input logic [W-1:0] b, input int p);
    logic [2*W-1:0] mask;
    int r;
    r = W - p * G;
    mask = ~(((2*W)'(1) << r) - 1);
    return {{W{1'b0}}, a} * ({{W{1'b0}}, b} & mask);
  endfunction

  function automatic logic [2*W-1:0] ref_gap(input logic [W-1:0] a, input int p);
    int r;
    r = W - p * G;
    return {{W{1'b0}}, a} * (((2*W)'(1) << r) - 1);
  endfunction

  // Runs one operation against a behavioural model; halt_at = phase number
  // before which halt is raised (0 = never); poke = restart attempt mid-run.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [2*W-1:0] th, input int mp,
                        input int halt_at, input bit poke, input string tag);
    logic [2*W-1:0] exact, elo, ehi, prev_span, hold_lo, hold_hi;
    int budget, last_ph;
    bit stop;
    exact  = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    budget = (mp == 0 || mp > GROUPS) ? GROUPS : mp;
    @(negedge clk);
    start = 1'b1; a_in = a; b_in = b; err_limit = th; phase_limit = PW'(mp);
    @(negedge clk);
    start = 1'b0; a_in = ~a; b_in = ~b;
    chk(done == 1'b0, "R2", {tag, " done cleared"}, 128'(done), 0);
    chk(lo_bound == 0 && phase == 0, "R2", {tag, " initial lo"}, lo_bound, 0);
    chk(hi_bound == ref_gap(a, 0), "R2", {tag, " initial hi"}, hi_bound, ref_gap(a, 0));
    prev_span = span;
    last_ph = 0;
    for (int p = 1; p <= GROUPS; p++) begin
      if (halt_at == p) halt = 1'b1;
      if (poke && p == 2) begin
        start = 1'b1; a_in = ~a; b_in = b ^ 64'hFFFF;
      end
      hold_lo = lo_bound;
      @(negedge clk);
      halt = 1'b0; start = 1'b0;
      if (halt_at == p) begin
        chk(done && !phase_valid, "R8", {tag, " halt done"}, {done, phase_valid}, 2'b10);
        chk(lo_bound == hold_lo && int'(phase) == last_ph, "R8", {tag, " halt keeps bounds"}, lo_bound, hold_lo);
        break;
      end
      elo = ref_lo(a, b, p);
      ehi = elo + ref_gap(a, p);
      chk(phase_valid && int'(phase) == p, "R11", {tag, " phase strobe"}, 128'(phase), 128'(p));
      chk(lo_bound == elo, poke ? "R9" : "R3", {tag, " lower bound"}, lo_bound, elo);
      chk(hi_bound == ehi, "R3", {tag, " upper bound"}, hi_bound, ehi);
      chk(lo_bound <= exact && exact <= hi_bound, "R3", {tag, " encloses product"}, exact, lo_bound);
      chk(span == hi_bound - lo_bound && span <= prev_span, "R4", {tag, " width"}, span, ehi - elo);
      if (p == GROUPS)
        chk(lo_bound == exact && hi_bound == exact && span == 0, "R5", {tag, " exact final"}, lo_bound, exact);
      stop = (ehi - elo <= th) || (p >= budget);
      chk(done == stop, (p >= budget) ? "R7" : "R6", {tag, " done on phase"}, 128'(done), 128'(stop));
      prev_span = span;
      last_ph = p;
      if (stop) break;
    end
    hold_lo = lo_bound; hold_hi = hi_bound;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(done && !phase_valid && lo_bound == hold_lo && hi_bound == hold_hi,
          "R10", {tag, " result held"}, lo_bound, hold_lo);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; halt = 1'b0; a_in = '0; b_in = '0;
    err_limit = '0; phase_limit = '0;
    #(CLK_PERIOD * 2 + 3);
    chk(!done && !phase_valid && lo_bound == 0 && hi_bound == 0 && span == 0 && phase == 0,
        "R1", "reset state", lo_bound, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !phase_valid && phase == 0, "R1", "after release", 128'(done), 0);

    run_op('1, '1, 0, 0, 0, 0, "max operands");
    run_op(64'h1234_5678_9ABC_DEF0, 64'hFEDC_BA98_7654_3210, 0, 0, 0, 0, "mixed");
    run_op(64'hDEAD_BEEF_0000_0001, 64'h0F0F_F0F0_1234_8765, 0, 2, 0, 0, "budget2");
    run_op(64'h0000_0000_0000_0003, 64'h8000_0000_0000_0001, ref_gap(64'h3, 1), 0, 0, 0, "limit eq w1");
    run_op(64'hFFFF_0000_FFFF_0000, 64'hAAAA_5555_AAAA_5555, ref_gap(64'hFFFF_0000_FFFF_0000, 2), 0, 0, 0, "limit eq w2");
    run_op(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, "zero a");
    run_op(64'h7777_1111_2222_3333, 64'h0123_4567_89AB_CDEF, 0, 7, 0, 0, "budget over");
    run_op(64'hC0FF_EE00_1234_5678, 64'h9999_8888_7777_6666, 0, 0, 3, 0, "halt mid");
    run_op(64'h5, 64'h6, 0, 0, 1, 0, "halt first");
    run_op(64'hA5A5_A5A5_5A5A_5A5A, 64'h3C3C_C3C3_0FF0_F00F, 0, 0, 0, 1, "restart ignored");
    run_op(64'h1, 64'h1, 0, 1, 0, 0, "budget1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule